// File: doc/BRIEF.md
# CAN Transmit Request and Retry Flag Controller

This block keeps two flags for each message object of a CAN controller: a pending-send flag and a fresh-data flag. The host CPU arms an object through a small write port. The block picks the lowest-numbered armed object and offers it to the protocol engine for loading into the shift register. It then updates both flags as the engine reports that a frame started, finished cleanly, lost arbitration or hit a bus error.

A single-shot input selects one of two retry policies. It is clear by default, and then a failed frame stays armed and is offered again until it completes. When the input is set, the block suits time-triggered operation. The pending-send flag drops as soon as the frame starts, and the fresh-data flag drops only on a clean finish. A frame that fails therefore stays unconfirmed but is not retried until the CPU arms it again. The policy is latched when a frame starts and governs that frame until it ends.

Top module: `tx_retx_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every pending-send and fresh-data flag becomes 0, and `sel_valid_o` is 0.
- R2: A CPU write (`cpu_set_i`=1) sets both flags of object `cpu_set_idx_i` at the next edge.
- R3: `sel_valid_o` is 1 exactly when some pending-send flag is set. `sel_idx_o` is then the lowest set index, and it is 0 otherwise.
- R4: A start pulse is accepted only when no frame is in flight and `sel_valid_o` is 1. An accepted start makes `sel_idx_o` the in-flight object. A start pulse at any other time has no effect on the flags.
- R5: With `single_shot_i`=0 at start, a start leaves the flags unchanged. A lost-arbitration or error report leaves both flags of the in-flight object set, so the object is offered again.
- R6: With `single_shot_i`=0 at start, a clean-finish report clears both flags of the in-flight object at the next edge.
- R7: With `single_shot_i`=1 at an accepted start, the object's pending-send flag clears at the next edge, and its fresh-data flag is kept.
- R8: With `single_shot_i`=1 at start, a clean-finish report clears the fresh-data flag, while a lost-arbitration or error report keeps it set. In both cases the object is not offered again until the CPU writes it.
- R9: A CPU write to an object in the same cycle as a hardware clear of that object's flags wins: both flags end up set.
- R10: Finish, lost-arbitration and error reports arriving while no frame is in flight have no effect.
- R11: The policy is sampled at the accepted start. A change of `single_shot_i` during the frame does not alter how its completion is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| single_shot_i | input | 1 | 1 disables automatic retry |
| cpu_set_i | input | 1 | CPU arms an object |
| cpu_set_idx_i | input | IDX_W | Object armed by the CPU |
| pe_start_i | input | 1 | Engine begins sending the offered object |
| pe_done_i | input | 1 | In-flight frame finished cleanly |
| pe_lost_i | input | 1 | In-flight frame lost arbitration |
| pe_error_i | input | 1 | In-flight frame hit a bus error |
| req_o | output | NUM_OBJ | Pending-send flags, one per object |
| ndat_o | output | NUM_OBJ | Fresh-data flags, one per object |
| sel_valid_o | output | 1 | Some object is pending |
| sel_idx_o | output | IDX_W | Lowest pending object |

## Verification
The checker assumes that the engine reports at most one of finish, lost and error per cycle. It also assumes that start and a completion report never coincide for the same frame, and that `cpu_set_idx_i` names an existing object. The stimulus table drives one engine event per row and only valid indices. The properties are therefore written with these inputs in mind. Where a CPU write could collide with a hardware clear, that case is excluded from the property and covered by directed rows instead.

// File: rtl/tx_retx_pkg.sv
package tx_retx_pkg;

    typedef struct packed {
        logic start;
        logic done;
        logic lost;
        logic error;
    } pe_evt_t;

    typedef enum logic {
        RETX_AUTO   = 1'b0,
        RETX_SINGLE = 1'b1
    } retx_mode_e;

    function automatic logic evt_ends(input pe_evt_t e);
        return e.done | e.lost | e.error;
    endfunction

endpackage

// File: rtl/tx_req_slot.sv
module tx_req_slot (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_req_i,
    input  logic clr_ndat_i,
    output logic req_o,
    output logic ndat_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_o  <= 1'b0;
            ndat_o <= 1'b0;
        end else if (set_i) begin
            req_o  <= 1'b1;
            ndat_o <= 1'b1;
        end else begin
            if (clr_req_i)  req_o  <= 1'b0;
            if (clr_ndat_i) ndat_o <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_req_pick.sv
module tx_req_pick #(
    parameter int NUM_OBJ = 8,
    parameter int IDX_W   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  logic [NUM_OBJ-1:0] req_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_OBJ - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tx_active_trk.sv
module tx_active_trk
    import tx_retx_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  pe_evt_t          evt_i,
    input  retx_mode_e       mode_i,
    input  logic             sel_valid_i,
    input  logic [IDX_W-1:0] sel_idx_i,
    output logic             start_ok_o,
    output logic             done_ok_o,
    output logic             busy_o,
    output logic [IDX_W-1:0] act_idx_o,
    output retx_mode_e       act_mode_o
);
    assign start_ok_o = evt_i.start & sel_valid_i & ~busy_o;
    assign done_ok_o  = evt_i.done & busy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o     <= 1'b0;
            act_idx_o  <= '0;
            act_mode_o <= RETX_AUTO;
        end else if (start_ok_o) begin
            busy_o     <= 1'b1;
            act_idx_o  <= sel_idx_i;
            act_mode_o <= mode_i;
        end else if (busy_o && evt_ends(evt_i)) begin
            busy_o <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_retx_ctrl.sv
module tx_retx_ctrl
    import tx_retx_pkg::*;
#(
    parameter int NUM_OBJ = 8,
    localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               single_shot_i,
    input  logic               cpu_set_i,
    input  logic [IDX_W-1:0]   cpu_set_idx_i,
    input  logic               pe_start_i,
    input  logic               pe_done_i,
    input  logic               pe_lost_i,
    input  logic               pe_error_i,
    output logic [NUM_OBJ-1:0] req_o,
    output logic [NUM_OBJ-1:0] ndat_o,
    output logic               sel_valid_o,
    output logic [IDX_W-1:0]   sel_idx_o
);
    pe_evt_t          evt;
    retx_mode_e       mode;
    logic             start_ok, done_ok, busy;
    logic [IDX_W-1:0] act_idx;
    retx_mode_e       act_mode;

    assign evt  = '{start: pe_start_i, done: pe_done_i, lost: pe_lost_i, error: pe_error_i};
    assign mode = single_shot_i ? RETX_SINGLE : RETX_AUTO;

    tx_req_pick #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_pick (
        .req_i   (req_o),
        .valid_o (sel_valid_o),
        .idx_o   (sel_idx_o)
    );

    tx_active_trk #(.IDX_W(IDX_W)) u_trk (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .mode_i      (mode),
        .sel_valid_i (sel_valid_o),
        .sel_idx_i   (sel_idx_o),
        .start_ok_o  (start_ok),
        .done_ok_o   (done_ok),
        .busy_o      (busy),
        .act_idx_o   (act_idx),
        .act_mode_o  (act_mode)
    );

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_slot
        logic hit_sel, hit_act, set, clr_req, clr_ndat;
        assign hit_sel  = (sel_idx_o == IDX_W'(g));
        assign hit_act  = (act_idx == IDX_W'(g));
        assign set      = cpu_set_i && (cpu_set_idx_i == IDX_W'(g));
        assign clr_req  = (start_ok && mode == RETX_SINGLE && hit_sel) ||
                          (done_ok && act_mode == RETX_AUTO && hit_act);
        assign clr_ndat = done_ok && hit_act;

        tx_req_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .set_i      (set),
            .clr_req_i  (clr_req),
            .clr_ndat_i (clr_ndat),
            .req_o      (req_o[g]),
            .ndat_o     (ndat_o[g])
        );
    end
endmodule

// File: rtl/tx_retx_ctrl_chk.sv
module tx_retx_ctrl_chk #(
    parameter int NUM_OBJ = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               single_shot_i,
    input logic               cpu_set_i,
    input logic [IDX_W-1:0]   cpu_set_idx_i,
    input logic               pe_start_i,
    input logic               pe_done_i,
    input logic               pe_lost_i,
    input logic               pe_error_i,
    input logic [NUM_OBJ-1:0] req_o,
    input logic [NUM_OBJ-1:0] ndat_o,
    input logic               sel_valid_o,
    input logic [IDX_W-1:0]   sel_idx_o,
    input logic               busy,
    input logic [IDX_W-1:0]   act_idx,
    input logic               act_single
);
    logic rst_q;
    logic start_ok;
    always_ff @(posedge clk) rst_q <= rst;
    assign start_ok = pe_start_i && sel_valid_o && !busy;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (req_o == '0 && ndat_o == '0 && !sel_valid_o));

    // R2, and R9 since the write wins over any clear
    p_cpu_set_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_set_i |=> (req_o[$past(cpu_set_idx_i)] && ndat_o[$past(cpu_set_idx_i)]));

    p_pick_lowest_r3: assert property (@(posedge clk) disable iff (rst)
        sel_valid_o |-> (req_o[sel_idx_o] &&
                         ((req_o & ((NUM_OBJ'(1) << sel_idx_o) - NUM_OBJ'(1))) == '0)));

    p_auto_fail_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !act_single && (pe_lost_i || pe_error_i) && !pe_done_i)
        |=> req_o[$past(act_idx)]);

    p_auto_done_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !act_single && pe_done_i && !(cpu_set_i && cpu_set_idx_i == act_idx))
        |=> (!req_o[$past(act_idx)] && !ndat_o[$past(act_idx)]));

    p_single_start_r7: assert property (@(posedge clk) disable iff (rst)
        (start_ok && single_shot_i && !(cpu_set_i && cpu_set_idx_i == sel_idx_o))
        |=> (!req_o[$past(sel_idx_o)] && ndat_o[$past(sel_idx_o)] == $past(ndat_o[sel_idx_o])));

    p_idle_no_effect_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !pe_start_i && !cpu_set_i) |=> ($stable(req_o) && $stable(ndat_o)));
endmodule

bind tx_retx_ctrl tx_retx_ctrl_chk #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .single_shot_i (single_shot_i),
    .cpu_set_i     (cpu_set_i),
    .cpu_set_idx_i (cpu_set_idx_i),
    .pe_start_i    (pe_start_i),
    .pe_done_i     (pe_done_i),
    .pe_lost_i     (pe_lost_i),
    .pe_error_i    (pe_error_i),
    .req_o         (req_o),
    .ndat_o        (ndat_o),
    .sel_valid_o   (sel_valid_o),
    .sel_idx_o     (sel_idx_o),
    .busy          (busy),
    .act_idx       (act_idx),
    .act_single    (act_mode == tx_retx_pkg::RETX_SINGLE)
);

// File: tb/tx_retx_ctrl_test.sv
module tx_retx_ctrl_test;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam int NV = 27;

    typedef struct packed {
        logic          cpu;
        logic [IW-1:0] cidx;
        logic          st, dn, lo, er, ss;
        logic [N-1:0]  ereq, endat;
        logic          ev;
        logic [IW-1:0] esel;
        logic [3:0]    tag;
    } vec_t;

    // cpu cidx st dn lo er ss | exp req, ndat, valid, sel | requirement
    localparam vec_t VECS [NV] = '{
        '{1'b1,3'd5,1'b0,1'b0,1'b0,1'b0,1'b0,8'h20,8'h20,1'b1,3'd5,4'd2},  // R2
        '{1'b1,3'd2,1'b0,1'b0,1'b0,1'b0,1'b0,8'h24,8'h24,1'b1,3'd2,4'd3},  // R3
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h24,8'h24,1'b1,3'd2,4'd4},  // R4 start obj 2
        '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h24,8'h24,1'b1,3'd2,4'd5},  // R5 lost
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h24,8'h24,1'b1,3'd2,4'd4},  // R4
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h24,8'h24,1'b1,3'd2,4'd5},  // R5 error
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h24,8'h24,1'b1,3'd2,4'd4},  // R4
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h20,8'h20,1'b1,3'd5,4'd6},  // R6
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h20,8'h20,1'b1,3'd5,4'd10}, // R10
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,8'h20,1'b0,3'd0,4'd7},  // R7
        '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h20,1'b0,3'd0,4'd8},  // R8 fail
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,8'h20,1'b0,3'd0,4'd4},  // R4 none pending
        '{1'b1,3'd5,1'b0,1'b0,1'b0,1'b0,1'b1,8'h20,8'h20,1'b1,3'd5,4'd8},  // R8 re-arm
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,8'h20,1'b0,3'd0,4'd7},  // R7
        '{1'b1,3'd3,1'b0,1'b0,1'b0,1'b0,1'b1,8'h08,8'h28,1'b1,3'd3,4'd2},  // R2
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h08,8'h28,1'b1,3'd3,4'd4},  // R4 busy
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h08,8'h08,1'b1,3'd3,4'd8},  // R8 done
        '{1'b1,3'd7,1'b0,1'b0,1'b0,1'b0,1'b0,8'h88,8'h88,1'b1,3'd3,4'd2},  // R2
        '{1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h8A,8'h8A,1'b1,3'd1,4'd3},  // R3
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h8A,8'h8A,1'b1,3'd1,4'd5},  // R5
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h88,8'h88,1'b1,3'd3,4'd11}, // R11
        '{1'b1,3'd3,1'b1,1'b0,1'b0,1'b0,1'b1,8'h88,8'h88,1'b1,3'd3,4'd9},  // R9 vs start
        '{1'b1,3'd3,1'b0,1'b1,1'b0,1'b0,1'b1,8'h88,8'h88,1'b1,3'd3,4'd9},  // R9 vs done
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h88,8'h88,1'b1,3'd3,4'd4},  // R4
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h80,8'h80,1'b1,3'd7,4'd6},  // R6
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h80,8'h80,1'b1,3'd7,4'd4},  // R4
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,3'd0,4'd6}   // R6
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          single_shot_i = 1'b0, cpu_set_i = 1'b0;
    logic [IW-1:0] cpu_set_idx_i = '0;
    logic          pe_start_i = 1'b0, pe_done_i = 1'b0, pe_lost_i = 1'b0, pe_error_i = 1'b0;
    logic [N-1:0]  req_o, ndat_o;
    logic          sel_valid_o;
    logic [IW-1:0] sel_idx_o;
    int            checks = 0, errors = 0;
    bit            finished = 1'b0;

    always #10 clk = ~clk;

    tx_retx_ctrl #(.NUM_OBJ(N)) uut (
        .clk(clk), .rst(rst), .single_shot_i(single_shot_i),
        .cpu_set_i(cpu_set_i), .cpu_set_idx_i(cpu_set_idx_i),
        .pe_start_i(pe_start_i), .pe_done_i(pe_done_i),
        .pe_lost_i(pe_lost_i), .pe_error_i(pe_error_i),
        .req_o(req_o), .ndat_o(ndat_o),
        .sel_valid_o(sel_valid_o), .sel_idx_o(sel_idx_o)
    );

    task automatic check(input int tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_state(input int tag, input logic [N-1:0] er, input logic [N-1:0] en,
                               input logic ev, input logic [IW-1:0] es);
        check(tag, "req_o", 32'(req_o), 32'(er));
        check(tag, "ndat_o", 32'(ndat_o), 32'(en));
        check(tag, "sel_valid_o", 32'(sel_valid_o), 32'(ev));
        check(tag, "sel_idx_o", 32'(sel_idx_o), 32'(es));
    endtask

    task automatic idle_inputs();
        cpu_set_i = 1'b0; pe_start_i = 1'b0; pe_done_i = 1'b0;
        pe_lost_i = 1'b0; pe_error_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_state(1, '0, '0, 1'b0, '0);       // R1 reset state
        rst = 1'b0;
        for (int k = 0; k < NV; k++) begin
            cpu_set_i     = VECS[k].cpu;
            cpu_set_idx_i = VECS[k].cidx;
            pe_start_i    = VECS[k].st;
            pe_done_i     = VECS[k].dn;
            pe_lost_i     = VECS[k].lo;
            pe_error_i    = VECS[k].er;
            single_shot_i = VECS[k].ss;
            @(negedge clk);
            check_state(int'(VECS[k].tag), VECS[k].ereq, VECS[k].endat, VECS[k].ev, VECS[k].esel);
        end
        idle_inputs();
        // R1: reset in the middle of activity
        cpu_set_i = 1'b1; cpu_set_idx_i = 3'd4;
        @(negedge clk);
        cpu_set_i = 1'b0; cpu_set_idx_i = 3'd6; single_shot_i = 1'b1; pe_start_i = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check_state(1, '0, '0, 1'b0, '0);
        rst = 1'b0; pe_start_i = 1'b0; pe_lost_i = 1'b1;
        @(negedge clk);
        check_state(10, '0, '0, 1'b0, '0);      // R10 lost with nothing in flight
        idle_inputs();
        // R3: highest and lowest objects together
        cpu_set_i = 1'b1; cpu_set_idx_i = 3'd7;
        @(negedge clk);
        cpu_set_idx_i = 3'd0;
        @(negedge clk);
        idle_inputs();
        check_state(3, 8'h81, 8'h81, 1'b1, 3'd0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule